// File: doc/BRIEF.md
# Write Completion Status Reporter

This block chooses the byte that a nonvolatile memory puts on its read bus while an internally timed write or erase runs. The host then polls that byte to learn when the operation is done. The block gives two separate completion indicators on the same byte:

- Bit 7 returns the complement of bit 7 of the last byte loaded, and returns the true value once the operation has finished.
- Bit 6 flips on every read strobe while the operation runs, and stops flipping when it ends.

Array reads on the full byte become trustworthy only after a settle interval that follows completion. The length of that interval is set by a cycle-count parameter.

The surrounding controller raises `busy_i` when the load phase ends and the internal cycle starts. It also supplies the remaining inputs:

- `erase_i`, which says whether the operation is a chip erase.
- The last loaded byte.
- The true array read data.

A read is the clock cycle in which `rd_stb_i` is high. The value of `rd_data_o` in that cycle is the value the host sees.

Top module: `write_status_reporter`

## Requirements
- R1: While `busy_i` is high and `erase_i` is low, bit 7 of `rd_data_o` equals the inverse of bit 7 of `last_byte_i`.
- R2: While `busy_i` is high, bit 6 of `rd_data_o` changes value after every cycle with `rd_stb_i` high, and keeps its value across busy cycles without a strobe.
- R3: The first read of every busy period returns 1 on bit 6, even when the previous busy period ended on a read that returned 1.
- R4: While `busy_i` and `erase_i` are both high, bit 7 reads 0. Bit 6 still toggles as in R2.
- R5: Bits 5 to 0 of `rd_data_o` read 0 while `busy_i` is high and during the settle interval.
- R6: Once `busy_i` falls, bits 7 and 6 pass `array_data_i` through at once and no longer toggle. For exactly `SETTLE_CYC` cycles the low six bits stay 0. After that the whole byte equals `array_data_i`.
- R7: After reset, and whenever no busy period or settle interval is in progress, `rd_data_o` equals `array_data_i`.
- R8: If `busy_i` rises again during a settle interval, that interval is abandoned. Busy reporting (R1 to R5) applies at once, and a full settle interval of `SETTLE_CYC` cycles follows the new completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| busy_i | input | 1 | Internal write or erase cycle in progress |
| erase_i | input | 1 | High when the running operation is a chip erase |
| last_byte_i | input | 8 | Data of the last byte loaded before the internal cycle |
| rd_stb_i | input | 1 | Host read strobe, one cycle per read |
| array_data_i | input | 8 | True array data at the read address |
| rd_data_o | output | 8 | Byte returned on the read bus |

## Verification
The assertions assume the following about the inputs:

- `busy_i` is low throughout reset.
- `erase_i` and `last_byte_i` stay constant for the whole of a busy period.
- `array_data_i` holds the completed data from the cycle in which `busy_i` falls.

The stimulus changes every input only on the falling clock edge. It sets `erase_i` and `last_byte_i` in the same cycle that raises `busy_i`, and it loads the array value in the same cycle that drops `busy_i`. The host polling model deliberately drops `busy_i` in the same cycle as a read strobe. That read is treated as suspect, and completion is confirmed with two further matching reads.

// File: rtl/wcs_pkg.sv
package wcs_pkg;

    localparam int POLL_BIT = 7;
    localparam int TGL_BIT  = 6;
    localparam int LOW_W    = 6;

    typedef enum logic [1:0] {
        PH_READY  = 2'd0,
        PH_BUSY   = 2'd1,
        PH_SETTLE = 2'd2
    } phase_e;

    typedef struct packed {
        logic             poll;
        logic             tgl;
        logic [LOW_W-1:0] low;
    } rd_word_t;

    function automatic rd_word_t busy_word(input logic erase, input logic last7, input logic tgl);
        rd_word_t w;
        w.poll = erase ? 1'b0 : ~last7;
        w.tgl  = tgl;
        w.low  = '0;
        return w;
    endfunction

    function automatic rd_word_t settle_word(input logic [7:0] arr);
        rd_word_t w;
        w.poll = arr[POLL_BIT];
        w.tgl  = arr[TGL_BIT];
        w.low  = '0;
        return w;
    endfunction

endpackage

// File: rtl/wcs_phase.sv
module wcs_phase
    import wcs_pkg::*;
#(
    parameter int SETTLE_CYC = 200
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   busy_i,
    output phase_e phase_o
);
    localparam int CNT_W = $clog2(SETTLE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYC);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (busy_i) begin
            cnt_q <= CNT_LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_comb begin
        if (busy_i)            phase_o = PH_BUSY;
        else if (cnt_q != '0)  phase_o = PH_SETTLE;
        else                   phase_o = PH_READY;
    end

    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_LOAD); // R6
    AST_BUSY_RELOAD: assert property (@(posedge clk) disable iff (rst)
        busy_i |=> (cnt_q == CNT_LOAD)); // R8
    AST_SETTLE_STEP: assert property (@(posedge clk) disable iff (rst)
        (!busy_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R6

endmodule

// File: rtl/wcs_toggle.sv
module wcs_toggle (
    input  logic clk,
    input  logic rst,
    input  logic busy_i,
    input  logic rd_stb_i,
    output logic tgl_o
);
    logic tgl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tgl_q <= 1'b1;
        end else if (!busy_i) begin
            tgl_q <= 1'b1;
        end else if (rd_stb_i) begin
            tgl_q <= ~tgl_q;
        end
    end

    assign tgl_o = tgl_q;

    AST_TGL_FLIP: assert property (@(posedge clk) disable iff (rst)
        (busy_i && rd_stb_i) |=> (tgl_q != $past(tgl_q))); // R2
    AST_TGL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !rd_stb_i) |=> $stable(tgl_q)); // R2
    AST_TGL_PRESET: assert property (@(posedge clk) disable iff (rst)
        !busy_i |=> tgl_q); // R3

endmodule

// File: rtl/wcs_rdmux.sv
module wcs_rdmux
    import wcs_pkg::*;
(
    input  phase_e     phase_i,
    input  logic       erase_i,
    input  logic       last7_i,
    input  logic       tgl_i,
    input  logic [7:0] array_i,
    output logic [7:0] rd_o
);
    rd_word_t w;

    always_comb begin
        unique case (phase_i)
            PH_BUSY:   w = busy_word(erase_i, last7_i, tgl_i);
            PH_SETTLE: w = settle_word(array_i);
            default:   w = rd_word_t'(array_i);
        endcase
    end

    assign rd_o = w;

endmodule

// File: rtl/write_status_reporter.sv
module write_status_reporter
    import wcs_pkg::*;
#(
    parameter int SETTLE_CYC = 200
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       busy_i,
    input  logic       erase_i,
    input  logic [7:0] last_byte_i,
    input  logic       rd_stb_i,
    input  logic [7:0] array_data_i,
    output logic [7:0] rd_data_o
);
    phase_e phase;
    logic   tgl;

    wcs_phase #(.SETTLE_CYC(SETTLE_CYC)) i_phase (
        .clk     (clk),
        .rst     (rst),
        .busy_i  (busy_i),
        .phase_o (phase)
    );

    wcs_toggle i_toggle (
        .clk      (clk),
        .rst      (rst),
        .busy_i   (busy_i),
        .rd_stb_i (rd_stb_i),
        .tgl_o    (tgl)
    );

    wcs_rdmux i_rdmux (
        .phase_i (phase),
        .erase_i (erase_i),
        .last7_i (last_byte_i[POLL_BIT]),
        .tgl_i   (tgl),
        .array_i (array_data_i),
        .rd_o    (rd_data_o)
    );

    AST_POLL_INV: assert property (@(posedge clk) disable iff (rst)
        (busy_i && !erase_i) |-> (rd_data_o[7] != last_byte_i[7])); // R1
    AST_ERASE_B7: assert property (@(posedge clk) disable iff (rst)
        (busy_i && erase_i) |-> !rd_data_o[7]); // R4
    AST_FIRST_ONE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy_i) |-> rd_data_o[6]); // R3
    AST_LOW_ZERO: assert property (@(posedge clk) disable iff (rst)
        busy_i |-> (rd_data_o[5:0] == 6'd0)); // R5
    AST_DONE_TRUE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_i) |-> (rd_data_o[7:6] == array_data_i[7:6] && rd_data_o[5:0] == 6'd0)); // R6

endmodule

// File: tb/test_write_status_reporter.sv
module test_write_status_reporter;
    localparam int S = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       busy = 1'b0;
    logic       erase = 1'b0;
    logic [7:0] last_b = 8'h00;
    logic       rd_stb = 1'b0;
    logic [7:0] arr = 8'h00;
    logic [7:0] rd;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    write_status_reporter #(.SETTLE_CYC(S)) i_write_status_reporter (
        .clk(clk), .rst(rst), .busy_i(busy), .erase_i(erase),
        .last_byte_i(last_b), .rd_stb_i(rd_stb), .array_data_i(arr),
        .rd_data_o(rd)
    );

    // vector fields: {last byte[7:0], erase, read count[2:0]}
    localparam logic [11:0] VEC [5] = '{
        {8'h80, 1'b0, 3'd3},
        {8'h3C, 1'b0, 3'd4},
        {8'hFF, 1'b1, 3'd5},
        {8'h00, 1'b1, 3'd2},
        {8'h7F, 1'b0, 3'd6}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_read(output logic [7:0] v);
        @(negedge clk);
        rd_stb = 1'b1;
        #1 v = rd;
        @(negedge clk);
        rd_stb = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        logic [7:0] prev;
        int nrd;
        repeat (3) @(negedge clk);
        arr = 8'h5A;
        rst = 1'b0;
        #1 check("R7 reset state", rd, 8'h5A);

        // table of busy periods
        for (int k = 0; k < 5; k++) begin
            logic [7:0] lb;
            logic er;
            int cnt;
            logic exp6;
            lb = VEC[k][11:4];
            er = VEC[k][3];
            cnt = int'(VEC[k][2:0]);
            @(negedge clk);
            last_b = lb; erase = er; busy = 1'b1;
            exp6 = 1'b1;
            for (int r = 0; r < cnt; r++) begin
                do_read(v);
                check(er ? "R4 erase bit7/bit6" : "R1 R2 R3 R5 busy read", v,
                      {er ? 1'b0 : ~lb[7], exp6, 6'd0});
                exp6 = ~exp6;
            end
            // hold: a non-strobe cycle must not flip bit 6 (R2)
            @(negedge clk);
            #1 check("R2 hold without strobe", rd, {er ? 1'b0 : ~lb[7], exp6, 6'd0});
            @(negedge clk);
            busy = 1'b0; arr = 8'hC3 ^ lb;
            repeat (S + 1) @(negedge clk);
        end

        // settle interval timing
        @(negedge clk);
        last_b = 8'h11; erase = 1'b0; busy = 1'b1;
        do_read(v);
        check("R3 first read after odd end", v, 8'hC0);
        @(negedge clk);
        busy = 1'b0; arr = 8'hBF;
        #1 check("R6 settle start", rd, 8'h80);
        repeat (S - 1) @(negedge clk);
        #1 check("R6 settle last cycle", rd, 8'h80);
        @(negedge clk);
        #1 check("R6 full data after settle", rd, 8'hBF);
        do_read(v);
        do_read(prev);
        check("R6 no toggle after done", v, prev);

        // re-busy during settle
        @(negedge clk);
        busy = 1'b1; last_b = 8'h01;
        @(negedge clk);
        busy = 1'b0; arr = 8'h7E;
        repeat (10) @(negedge clk);
        busy = 1'b1; last_b = 8'hF0;
        #1 check("R8 busy during settle", rd, 8'h40);
        @(negedge clk);
        busy = 1'b0;
        repeat (S - 1) @(negedge clk);
        #1 check("R8 full settle restarted", rd, 8'h40);
        @(negedge clk);
        #1 check("R8 data after restarted settle", rd, 8'h7E);

        // host toggle-polling model, completion coincides with a read
        @(negedge clk);
        last_b = 8'h2D; erase = 1'b0; busy = 1'b1;
        do_read(prev);
        nrd = 1;
        while (1) begin
            @(negedge clk);
            if (nrd == 4) begin busy = 1'b0; arr = 8'hE6; end
            rd_stb = 1'b1;
            #1 v = rd;
            @(negedge clk);
            rd_stb = 1'b0;
            nrd++;
            if (v[6] == prev[6] || nrd > 20) break;
            prev = v;
        end
        check("R6 polling stops toggling", 8'(nrd), 8'd6);
        do_read(v);
        do_read(prev);
        check("R6 two confirming reads", v, prev);
        check("R6 confirm value", v, 8'hC0);
        repeat (S) @(negedge clk);
        #1 check("R7 idle pass-through", rd, 8'hE6);
        arr = 8'h0F;
        #1 check("R7 idle follows array", rd, 8'h0F);

        // reset mid-busy
        @(negedge clk);
        busy = 1'b1; last_b = 8'h00;
        do_read(v);
        @(negedge clk);
        rst = 1'b1; busy = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1 check("R7 idle after reset", rd, 8'h0F);
        finish_run();
    end

endmodule